// File: doc/BRIEF.md
# Byte-Read Conversion Result Registers

This block holds the outcomes of analog-to-digital conversions in four read-only 16-bit result registers. A CPU reads them over an 8-bit data path. Each 10-bit result sits in the top ten bits of its register, and the six bits below it are always zero. On the converter side, a write port carries a valid strobe, a 3-bit input channel number and the 10-bit result. The block maps the channel number to its result register and updates that register in one clock.

A 16-bit value cannot tear across two byte reads, because the lower byte is never read straight from a result register. Reading a register's upper byte returns that byte and, on the same edge, copies the register's lower byte into one shared holding byte. Every lower-byte read returns the holding byte. Software therefore reads the upper byte first and the lower byte second, and gets both halves from the same moment even if the converter writes between the two reads.

Top module: `adcres_regs`

## Requirements
- R1: After reset, all four result registers and the holding byte are zero, and `rd_data` is zero.
- R2: A read with an even `rd_addr` = 2k returns bits 15..8 of register k (result bits 9..2) on `rd_data` in the cycle after `rd_en`. Registers A, B, C and D have k = 0, 1, 2 and 3.
- R3: An upper-byte read copies bits 7..0 of the addressed register into the holding byte. A later odd-offset read returns that byte, {result[1:0], 6'b0}.
- R4: Bits 5..0 of every lower-byte read are zero.
- R5: A converter write with channel 4, 5, 6 or 7 updates register A, B, C or D. Channel 2 updates register C and channel 3 updates register D.
- R6: Converter writes with channel 0 or 1 change no register.
- R7: A converter write that lands between an upper-byte read and the following lower-byte read does not change the holding byte.
- R8: A lower-byte read made before any upper-byte read since reset returns zero.
- R9: When a converter write and an upper-byte read of the same register fall in the same cycle, the read returns the value from before the write, in both the upper byte and the captured lower byte.
- R10: Every odd offset (1, 3, 5, 7) returns the holding byte, whatever register the offset would otherwise name.
- R11: A converter write is visible to an upper-byte read issued in the next cycle.
- R12: While `rd_en` is low, `rd_data` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cv_valid | input | 1 | Converter write strobe |
| cv_chan | input | 3 | Input channel number of the result |
| cv_data | input | 10 | Conversion result |
| rd_en | input | 1 | CPU read strobe |
| rd_addr | input | 3 | Byte offset: bits 2..1 select the register, bit 0 selects the holding byte |
| rd_data | output | 8 | Read data, valid in the cycle after `rd_en` |

## Verification
The bench builds the block with its default parameters: four registers, a 10-bit result, a 16-bit register and 2 as the lowest shared group-0 channel. With these values the full channel range 0 to 7 can be reached with 3 bits, so the bench drives every mapped channel and both ignored ones. It also tries every odd offset. The result values are chosen so that all four bit patterns of the two lowest result bits reach the holding byte.

// File: rtl/adcres_pkg.sv
package adcres_pkg;
   // Byte lane selected by bit 0 of the CPU offset
   typedef enum logic {
      LANE_UPPER = 1'b0,
      LANE_HOLD  = 1'b1
   } lane_e;

   function automatic int unsigned clog2_min1(input int unsigned v);
      int unsigned r;
      r = 0;
      while ((1 << r) < v) r++;
      return (r == 0) ? 1 : r;
   endfunction
endpackage

// File: rtl/adcres_chan_map.sv
module adcres_chan_map #(
   parameter int unsigned NUM_REGS  = 4,
   parameter int unsigned SHARED_LO = 2,
   parameter int unsigned CH_W      = 3
) (
   input  logic [CH_W-1:0]     chan,
   output logic [NUM_REGS-1:0] sel
);
   // Group 1: channels NUM_REGS .. 2*NUM_REGS-1 map to registers 0 .. NUM_REGS-1.
   // Group 0: channels SHARED_LO .. NUM_REGS-1 share the register of the same index.
   localparam int unsigned CH_SPAN = 1 << CH_W;

   if (2 * NUM_REGS > CH_SPAN) begin : g_bad_chw
      $error("adcres_chan_map: channel width too small for two groups");
   end
   if (SHARED_LO > NUM_REGS) begin : g_bad_shared
      $error("adcres_chan_map: SHARED_LO exceeds NUM_REGS");
   end

   for (genvar k = 0; k < NUM_REGS; k++) begin : g_sel
      localparam logic [CH_W-1:0] HI_CH = CH_W'(k + NUM_REGS);
      localparam logic [CH_W-1:0] LO_CH = CH_W'(k);
      if (k >= SHARED_LO) begin : g_shared
         assign sel[k] = (chan == HI_CH) || (chan == LO_CH);
      end else begin : g_solo
         assign sel[k] = (chan == HI_CH);
      end
   end
endmodule

// File: rtl/adcres_bank.sv
module adcres_bank #(
   parameter int unsigned NUM_REGS = 4,
   parameter int unsigned RES_W    = 10,
   parameter int unsigned REG_W    = 16
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            wr_valid,
   input  logic [NUM_REGS-1:0]             wr_sel,
   input  logic [RES_W-1:0]                wr_data,
   output logic [NUM_REGS-1:0][REG_W-1:0]  view
);
   localparam int unsigned PAD_W = REG_W - RES_W;

   if (RES_W > REG_W) begin : g_bad_width
      $error("adcres_bank: result wider than register");
   end

   for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
      logic [RES_W-1:0] res_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            res_q <= '0;
         end else if (wr_valid && wr_sel[k]) begin
            res_q <= wr_data;
         end
      end

      if (PAD_W > 0) begin : g_pad
         assign view[k] = {res_q, {PAD_W{1'b0}}};
      end else begin : g_nopad
         assign view[k] = res_q;
      end

      // R11: a selected write lands in this register on the next edge
      assert_write_lands_R11: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_valid && wr_sel[k]) |=> (view[k][REG_W-1 -: RES_W] == $past(wr_data)));
   end
endmodule

// File: rtl/adcres_rdport.sv
module adcres_rdport #(
   parameter int unsigned NUM_REGS = 4,
   parameter int unsigned REG_W    = 16,
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned ADDR_W   = 3
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            rd_en,
   input  logic [ADDR_W-1:0]               rd_addr,
   input  logic [NUM_REGS-1:0][REG_W-1:0]  view,
   output logic [DATA_W-1:0]               rd_data
);
   import adcres_pkg::*;

   localparam int unsigned IDX_W = ADDR_W - 1;

   if (REG_W != 2 * DATA_W) begin : g_bad_split
      $error("adcres_rdport: register must be exactly two bytes");
   end
   if ((1 << IDX_W) < NUM_REGS) begin : g_bad_addr
      $error("adcres_rdport: offset too narrow for register count");
   end

   lane_e             lane;
   logic [IDX_W-1:0]  idx;
   logic [DATA_W-1:0] hold_q;
   logic [DATA_W-1:0] upper_b;
   logic [DATA_W-1:0] lower_b;
   logic              in_range;

   assign lane     = lane_e'(rd_addr[0]);
   assign idx      = rd_addr[ADDR_W-1:1];
   assign in_range = (int'(idx) < NUM_REGS);

   always_comb begin
      upper_b = '0;
      lower_b = '0;
      for (int k = 0; k < NUM_REGS; k++) begin
         if (idx == IDX_W'(k)) begin
            upper_b = view[k][REG_W-1 -: DATA_W];
            lower_b = view[k][DATA_W-1:0];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q  <= '0;
         rd_data <= '0;
      end else if (rd_en) begin
         if (lane == LANE_UPPER) begin
            rd_data <= in_range ? upper_b : '0;
            if (in_range) hold_q <= lower_b;
         end else begin
            rd_data <= hold_q;
         end
      end
   end

   // R7: only an upper-byte read may touch the holding byte
   assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_en && lane == LANE_UPPER) |=> $stable(hold_q));

   // R12: without a strobe the output does not move
   assert_rd_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rd_data));

   // R4: lower-byte data never carries bits below the result
   assert_low_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && lane == LANE_HOLD) |=> (rd_data[5:0] == 6'd0));
endmodule

// File: rtl/adcres_regs.sv
module adcres_regs #(
   parameter int unsigned NUM_REGS  = 4,
   parameter int unsigned RES_W     = 10,
   parameter int unsigned REG_W     = 16,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned SHARED_LO = 2,
   parameter int unsigned CH_W      = 3,
   parameter int unsigned ADDR_W    = adcres_pkg::clog2_min1(NUM_REGS) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cv_valid,
   input  logic [CH_W-1:0]   cv_chan,
   input  logic [RES_W-1:0]  cv_data,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   logic [NUM_REGS-1:0]            sel;
   logic [NUM_REGS-1:0][REG_W-1:0] view;

   adcres_chan_map #(
      .NUM_REGS (NUM_REGS),
      .SHARED_LO(SHARED_LO),
      .CH_W     (CH_W)
   ) u_map (
      .chan(cv_chan),
      .sel (sel)
   );

   adcres_bank #(
      .NUM_REGS(NUM_REGS),
      .RES_W   (RES_W),
      .REG_W   (REG_W)
   ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_valid(cv_valid),
      .wr_sel  (sel),
      .wr_data (cv_data),
      .view    (view)
   );

   adcres_rdport #(
      .NUM_REGS(NUM_REGS),
      .REG_W   (REG_W),
      .DATA_W  (DATA_W),
      .ADDR_W  (ADDR_W)
   ) u_rd (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_en  (rd_en),
      .rd_addr(rd_addr),
      .view   (view),
      .rd_data(rd_data)
   );

   // R5: a channel never reaches more than one register
   assert_single_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cv_valid |-> $onehot0(sel));

   // R6: channels below the shared range leave every register untouched
   assert_ignored_chan_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cv_valid && (int'(cv_chan) < SHARED_LO)) |=> $stable(view));
endmodule

// File: tb/adcres_regs_tb_top.sv
module adcres_regs_tb_top;
   localparam int CLK_PERIOD = 10;

   typedef struct packed {
      logic       is_rd;
      logic [2:0] ch;
      logic [9:0] d;
      logic [2:0] a;
      logic [7:0] exp;
      logic [3:0] req;
   } vec_t;

   localparam int NVEC = 26;
   localparam vec_t VEC [NVEC] = '{
      '{1'b0, 3'd4, 10'h3A5, 3'd0, 8'h00, 4'd5},  // R5 ch4 -> A
      '{1'b1, 3'd0, 10'h000, 3'd0, 8'hE9, 4'd2},  // R2 upper A
      '{1'b1, 3'd0, 10'h000, 3'd1, 8'h40, 4'd3},  // R3 lower A
      '{1'b0, 3'd5, 10'h0FF, 3'd0, 8'h00, 4'd5},  // R5 ch5 -> B
      '{1'b1, 3'd0, 10'h000, 3'd2, 8'h3F, 4'd5},
      '{1'b1, 3'd0, 10'h000, 3'd3, 8'hC0, 4'd4},  // R4 low bits zero
      '{1'b0, 3'd2, 10'h201, 3'd0, 8'h00, 4'd5},  // R5 ch2 -> C
      '{1'b1, 3'd0, 10'h000, 3'd4, 8'h80, 4'd5},
      '{1'b1, 3'd0, 10'h000, 3'd5, 8'h40, 4'd3},
      '{1'b0, 3'd6, 10'h3FF, 3'd0, 8'h00, 4'd5},  // R5 ch6 -> C
      '{1'b1, 3'd0, 10'h000, 3'd4, 8'hFF, 4'd5},
      '{1'b1, 3'd0, 10'h000, 3'd7, 8'hC0, 4'd10}, // R10 any odd offset
      '{1'b0, 3'd3, 10'h002, 3'd0, 8'h00, 4'd5},  // R5 ch3 -> D
      '{1'b1, 3'd0, 10'h000, 3'd6, 8'h00, 4'd5},
      '{1'b1, 3'd0, 10'h000, 3'd7, 8'h80, 4'd3},
      '{1'b0, 3'd7, 10'h155, 3'd0, 8'h00, 4'd5},  // R5 ch7 -> D
      '{1'b1, 3'd0, 10'h000, 3'd6, 8'h55, 4'd5},
      '{1'b1, 3'd0, 10'h000, 3'd1, 8'h40, 4'd10},
      '{1'b1, 3'd0, 10'h000, 3'd3, 8'h40, 4'd10},
      '{1'b0, 3'd0, 10'h3FF, 3'd0, 8'h00, 4'd6},  // R6 ch0 ignored
      '{1'b0, 3'd1, 10'h000, 3'd0, 8'h00, 4'd6},  // R6 ch1 ignored
      '{1'b1, 3'd0, 10'h000, 3'd0, 8'hE9, 4'd6},
      '{1'b1, 3'd0, 10'h000, 3'd2, 8'h3F, 4'd6},
      '{1'b1, 3'd0, 10'h000, 3'd4, 8'hFF, 4'd6},
      '{1'b1, 3'd0, 10'h000, 3'd6, 8'h55, 4'd6},
      '{1'b1, 3'd0, 10'h000, 3'd5, 8'h40, 4'd10}
   };

   logic       clk;
   logic       rst_n;
   logic       cv_valid;
   logic [2:0] cv_chan;
   logic [9:0] cv_data;
   logic       rd_en;
   logic [2:0] rd_addr;
   logic [7:0] rd_data;

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   adcres_regs dut_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .cv_valid(cv_valid),
      .cv_chan (cv_chan),
      .cv_data (cv_data),
      .rd_en   (rd_en),
      .rd_addr (rd_addr),
      .rd_data (rd_data)
   );

   initial clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: rd_data actual %02h expected %02h", req, act, exp);
      end
   endtask

   // One cycle: inputs set at a falling edge, sampled at the next falling edge
   task automatic cycle(input logic wv, input logic [2:0] ch, input logic [9:0] d,
                        input logic re, input logic [2:0] a);
      @(negedge clk);
      cv_valid = wv; cv_chan = ch; cv_data = d;
      rd_en = re; rd_addr = a;
      @(negedge clk);
      cv_valid = 1'b0; rd_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string req);
      cycle(1'b0, 3'd0, 10'd0, 1'b1, a);
      check(req, rd_data, exp);
   endtask

   task automatic wr(input logic [2:0] ch, input logic [9:0] d);
      cycle(1'b1, ch, d, 1'b0, 3'd0);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not complete");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      cv_valid = 1'b0; cv_chan = '0; cv_data = '0;
      rd_en = 1'b0; rd_addr = '0; rst_n = 1'b0;
      do_reset();

      // R1: reset state at the port
      check("R1", rd_data, 8'h00);
      // R8: lower read before any upper read
      rd(3'd1, 8'h00, "R8");
      rd(3'd0, 8'h00, "R1");
      rd(3'd6, 8'h00, "R1");

      foreach (VEC[i]) begin
         if (VEC[i].is_rd) begin
            rd(VEC[i].a, VEC[i].exp, $sformatf("R%0d", VEC[i].req));
         end else begin
            wr(VEC[i].ch, VEC[i].d);
         end
      end

      // R7: write between upper and lower reads leaves holding byte alone
      rd(3'd0, 8'hE9, "R2");
      wr(3'd4, 10'h000);
      rd(3'd1, 8'h40, "R7");
      // R11: the write is visible to the next upper read
      rd(3'd0, 8'h00, "R11");
      rd(3'd1, 8'h00, "R3");

      // R9: same-cycle write and upper read return the old value
      cycle(1'b1, 3'd5, 10'h3C3, 1'b1, 3'd2);
      check("R9", rd_data, 8'h3F);
      rd(3'd1, 8'hC0, "R9");
      rd(3'd2, 8'hF0, "R11");

      // R12: idle cycles hold the last read value
      wr(3'd5, 10'h001);
      check("R12", rd_data, 8'hF0);
      cycle(1'b0, 3'd0, 10'd0, 1'b0, 3'd1);
      check("R12", rd_data, 8'hF0);

      // R8 and R1 again after a mid-run reset
      do_reset();
      check("R1", rd_data, 8'h00);
      rd(3'd3, 8'h00, "R8");
      rd(3'd2, 8'h00, "R1");

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule